// File: doc/BRIEF.md
# Device Model-Specific Register Bank with System Management Event Control

This block is the per-device bank of 64-bit model-specific registers that every device on the chip carries. Software reaches it through a single-cycle request port with a small register index and a write flag; one cycle later the bank returns a response with read data and an address-error indication. The bank holds six registers. Index 0 is a read-only identity word. Index 1 is configuration, index 2 is system-management event control, index 3 is error control, index 4 is power management, and index 5 is a reserved diagnostic slot.

The event-control register turns single-cycle event pulses from the device into sticky flags. The low half of the word holds one enable per event and the high half holds one flag per event, so event n pairs enable bit n with flag bit n+32. A parameter reverses the enable sense for device instances where a cleared enable is the one that allows recording. Each event belongs to one of two classes, asynchronous or synchronous, chosen by a mask parameter. The bank raises one request line for each class and a combined request while any flag is pending.

Top module: `dev_msr_bank`

## Requirements
- R1: After reset, resp_valid, smi_req, smi_async_req and smi_sync_req are 0, and the event-control word (index 2) reads 0, so all enables and flags are clear.
- R2: Index 0 reads {40'b0, DEV_ID[15:0], REV_ID[7:0]}, with the device identifier in bits 23:8 and the revision in bits 7:0. Writes to index 0 have no effect.
- R3: Indices 1 (configuration), 3 (error) and 4 (power management) reset to CFG_RST, ERR_RST and PM_RST. All 64 bits of each can be written and read back.
- R4: In the index-2 word, bits 31:0 are enables and bits 63:32 are flags. A write loads bits 31:0 of the write data into the enables.
- R5: A high evt_in[n] in a cycle records event n into flag bit n+32 only when enable bit n is 1 (EN_ACTIVE_LOW=0) or only when it is 0 (EN_ACTIVE_LOW=1). Enables written in the same cycle take effect from the next cycle.
- R6: A flag stays set until software writes 1 to its position in bits 63:32 of an index-2 write, which clears it. A 0 in that position leaves the flag unchanged.
- R7: When an event is recorded in the same cycle as a write that clears the same flag, the flag stays set.
- R8: smi_async_req is 1 while any flag whose ASYNC_MASK bit is 1 is set. smi_sync_req is 1 while any flag whose ASYNC_MASK bit is 0 is set. smi_req is their OR. All three follow the flag register.
- R9: Index 5 (diagnostic) ignores writes and reads as 0.
- R10: An access to index 6 or above returns resp_data 0 with resp_err 1 and changes no register. Accesses to indices 0 to 5 return resp_err 0.
- R11: Each accepted request (acc_valid=1) produces exactly one response with resp_valid=1 in the following cycle. A write response carries resp_data 0, and a read returns the register value from before any update in the request's own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Request strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | IDX_W | Register index |
| acc_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_data | output | 64 | Read data (0 for writes and errors) |
| resp_err | output | 1 | Index out of range |
| evt_in | input | 32 | Event pulses, one bit per event |
| smi_req | output | 1 | Any recorded flag pending |
| smi_async_req | output | 1 | Asynchronous-class flag pending |
| smi_sync_req | output | 1 | Synchronous-class flag pending |

## Verification
The assertions assume that evt_in, acc_valid and acc_index are known, two-valued levels at every rising edge once reset is released, and that an event is a level sampled at the edge rather than an edge to be detected. The bench changes every input only on the falling clock edge and holds each event mask for exactly one cycle. It leaves an idle cycle between requests, so each response can be matched to a single request. The request-rise property assumes that no flag can appear without an event pulse in the previous cycle, and the stimulus never forces state by any other path.

// File: rtl/dev_msr_pkg.sv
package dev_msr_pkg;

    localparam int MSR_W   = 64;
    localparam int HALF_W  = MSR_W / 2;
    localparam int NUM_EVT = HALF_W;
    localparam int NUM_STD = 6;
    localparam int RW_SLOTS = 3;

    typedef enum logic [2:0] {
        IDX_CAP  = 3'd0,
        IDX_CFG  = 3'd1,
        IDX_SMI  = 3'd2,
        IDX_ERR  = 3'd3,
        IDX_PM   = 3'd4,
        IDX_DIAG = 3'd5
    } msr_idx_e;

    typedef struct packed {
        logic [HALF_W-1:0] flag;
        logic [HALF_W-1:0] en;
    } smi_word_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [MSR_W-1:0]  data;
    } msr_resp_t;

    function automatic logic [MSR_W-1:0] cap_word(input logic [15:0] dev,
                                                  input logic [7:0]  rev);
        return {40'd0, dev, rev};
    endfunction

    function automatic logic [NUM_EVT-1:0] gate_events(input logic [NUM_EVT-1:0] evt,
                                                       input logic [NUM_EVT-1:0] en,
                                                       input logic               active_low);
        return evt & (active_low ? ~en : en);
    endfunction

    function automatic msr_idx_e rw_slot_index(input int slot);
        case (slot)
            0:       return IDX_CFG;
            1:       return IDX_ERR;
            default: return IDX_PM;
        endcase
    endfunction

endpackage

// File: rtl/msr_idx_decode.sv
module msr_idx_decode
    import dev_msr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                acc_valid,
    input  logic [IDX_W-1:0]    acc_index,
    output logic [NUM_STD-1:0]  sel,
    output logic                bad_idx
);

    for (genvar k = 0; k < NUM_STD; k++) begin : g_sel
        assign sel[k] = acc_valid && (acc_index == IDX_W'(k));
    end

    assign bad_idx = acc_valid && (acc_index >= IDX_W'(NUM_STD));

endmodule

// File: rtl/msr_rw_reg.sv
module msr_rw_reg
    import dev_msr_pkg::*;
#(
    parameter logic [MSR_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MSR_W-1:0]  wdata,
    output logic [MSR_W-1:0]  q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= wdata;
    end

endmodule

// File: rtl/msr_smi_ctrl.sv
module msr_smi_ctrl
    import dev_msr_pkg::*;
#(
    parameter logic               EN_ACTIVE_LOW = 1'b0,
    parameter logic [NUM_EVT-1:0] ASYNC_MASK    = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [MSR_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output smi_word_t          word,
    output logic               async_req,
    output logic               sync_req
);

    smi_word_t          word_q;
    smi_word_t          word_d;
    smi_word_t          wr_word;
    logic [NUM_EVT-1:0] rec;
    logic [NUM_EVT-1:0] clr;

    assign wr_word = smi_word_t'(wdata);
    assign rec     = gate_events(evt_in, word_q.en, EN_ACTIVE_LOW);
    assign clr     = we ? wr_word.flag : '0;

    always_comb begin
        word_d      = word_q;
        word_d.flag = (word_q.flag & ~clr) | rec;
        if (we) word_d.en = wr_word.en;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word      = word_q;
    assign async_req = |(word_q.flag & ASYNC_MASK);
    assign sync_req  = |(word_q.flag & ~ASYNC_MASK);

    // R5 R7
    rec_flag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((word_q.flag & $past(rec)) == $past(rec)));

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((word_q.flag & ~$past(word_q.flag) & ~$past(evt_in)) == '0));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> ((word_q.flag & $past(word_q.flag)) == $past(word_q.flag)));

endmodule

// File: rtl/dev_msr_bank.sv
module dev_msr_bank
    import dev_msr_pkg::*;
#(
    parameter int                 IDX_W         = 4,
    parameter logic [15:0]        DEV_ID        = 16'h0001,
    parameter logic [7:0]         REV_ID        = 8'h00,
    parameter logic               EN_ACTIVE_LOW = 1'b0,
    parameter logic [NUM_EVT-1:0] ASYNC_MASK    = '0,
    parameter logic [MSR_W-1:0]   CFG_RST       = '0,
    parameter logic [MSR_W-1:0]   ERR_RST       = '0,
    parameter logic [MSR_W-1:0]   PM_RST        = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [IDX_W-1:0]   acc_index,
    input  logic [MSR_W-1:0]   acc_wdata,
    output logic               resp_valid,
    output logic [MSR_W-1:0]   resp_data,
    output logic               resp_err,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               smi_req,
    output logic               smi_async_req,
    output logic               smi_sync_req
);

    localparam logic [MSR_W-1:0] CAP_VAL = cap_word(DEV_ID, REV_ID);

    logic [NUM_STD-1:0] sel;
    logic               bad_idx;
    logic [MSR_W-1:0]   rd_words [NUM_STD];
    logic [MSR_W-1:0]   rd_mux;
    smi_word_t          smi_word;
    msr_resp_t          resp_q;

    msr_idx_decode #(.IDX_W(IDX_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_index (acc_index),
        .sel       (sel),
        .bad_idx   (bad_idx)
    );

    assign rd_words[int'(IDX_CAP)]  = CAP_VAL;
    assign rd_words[int'(IDX_DIAG)] = '0;

    for (genvar g = 0; g < RW_SLOTS; g++) begin : g_rw
        localparam msr_idx_e         SLOT = rw_slot_index(g);
        localparam logic [MSR_W-1:0] RV   = (g == 0) ? CFG_RST :
                                            (g == 1) ? ERR_RST : PM_RST;
        msr_rw_reg #(.RST_VAL(RV)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (acc_write && sel[int'(SLOT)]),
            .wdata (acc_wdata),
            .q     (rd_words[int'(SLOT)])
        );
    end

    msr_smi_ctrl #(
        .EN_ACTIVE_LOW (EN_ACTIVE_LOW),
        .ASYNC_MASK    (ASYNC_MASK)
    ) u_smi (
        .clk       (clk),
        .rst       (rst),
        .we        (acc_write && sel[int'(IDX_SMI)]),
        .wdata     (acc_wdata),
        .evt_in    (evt_in),
        .word      (smi_word),
        .async_req (smi_async_req),
        .sync_req  (smi_sync_req)
    );

    assign rd_words[int'(IDX_SMI)] = smi_word;

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_STD; k++) begin
            if (sel[k]) rd_mux = rd_mux | rd_words[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= acc_valid;
            resp_q.err   <= bad_idx;
            resp_q.data  <= (acc_write || bad_idx) ? '0 : rd_mux;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_err   = resp_q.err;
    assign resp_data  = resp_q.data;
    assign smi_req    = smi_async_req | smi_sync_req;

    // R2
    cap_read_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_index == IDX_W'(IDX_CAP)) |=> (resp_data == CAP_VAL));

    // R9
    diag_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_index == IDX_W'(IDX_DIAG)) |=> (resp_data == '0));

    // R10
    err_resp_chk: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_valid && resp_data == '0));

    // R8
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(smi_req) |-> $past(|evt_in));

endmodule

// File: tb/tb_dev_msr_bank.sv
module tb_dev_msr_bank;
    import dev_msr_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          IW         = 4;
    localparam int          WD_CYCLES  = 20000;
    localparam logic [15:0] DEV        = 16'hA51C;
    localparam logic [7:0]  REV        = 8'h3B;
    localparam logic [63:0] CAP_EXP    = 64'h0000_0000_00A5_1C3B;
    localparam logic [63:0] CFG_R      = 64'h0000_0000_0000_0001;
    localparam logic [63:0] ERR_R      = 64'h0000_00FF_0000_0000;
    localparam logic [63:0] PM_R       = 64'h0000_0003_0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        v0 = 0, w0 = 0, v1 = 0, w1 = 0;
    logic [IW-1:0] i0 = '0, i1 = '0;
    logic [63:0] d0 = '0, d1 = '0;
    logic [31:0] e0 = '0, e1 = '0;
    logic        rv0, re0, sr0, sa0, ss0, rv1, re1, sr1, sa1, ss1;
    logic [63:0] rd0, rd1;

    dev_msr_bank #(
        .IDX_W(IW), .DEV_ID(DEV), .REV_ID(REV), .EN_ACTIVE_LOW(1'b0),
        .ASYNC_MASK(32'h0000_00F0), .CFG_RST(CFG_R), .ERR_RST(ERR_R), .PM_RST(PM_R)
    ) dut (
        .clk(clk), .rst(rst), .acc_valid(v0), .acc_write(w0), .acc_index(i0),
        .acc_wdata(d0), .resp_valid(rv0), .resp_data(rd0), .resp_err(re0),
        .evt_in(e0), .smi_req(sr0), .smi_async_req(sa0), .smi_sync_req(ss0)
    );

    dev_msr_bank #(
        .IDX_W(IW), .DEV_ID(DEV), .REV_ID(REV), .EN_ACTIVE_LOW(1'b1),
        .ASYNC_MASK(32'h0), .CFG_RST(CFG_R), .ERR_RST(ERR_R), .PM_RST(PM_R)
    ) dut_inv (
        .clk(clk), .rst(rst), .acc_valid(v1), .acc_write(w1), .acc_index(i1),
        .acc_wdata(d1), .resp_valid(rv1), .resp_data(rd1), .resp_err(re1),
        .evt_in(e1), .smi_req(sr1), .smi_async_req(sa1), .smi_sync_req(ss1)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] qd0[$], qd1[$];
    logic        qe0[$], qe1[$];
    string       qt0[$], qt1[$];

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitors: pop expected responses as the design produces them
    always @(negedge clk) begin
        if (rv0) begin
            if (qd0.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11 unexpected response (main): actual 1 expected 0");
            end else begin
                logic [63:0] xd; logic xe; string xt;
                xd = qd0.pop_front(); xe = qe0.pop_front(); xt = qt0.pop_front();
                check64(xt, rd0, xd);
                check64({xt, " err"}, {63'd0, re0}, {63'd0, xe});
            end
        end
        if (rv1) begin
            if (qd1.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11 unexpected response (inverted): actual 1 expected 0");
            end else begin
                logic [63:0] yd; logic ye; string yt;
                yd = qd1.pop_front(); ye = qe1.pop_front(); yt = qt1.pop_front();
                check64(yt, rd1, yd);
                check64({yt, " err"}, {63'd0, re1}, {63'd0, ye});
            end
        end
    end

    task automatic access(input int u, input bit wr, input logic [IW-1:0] idx,
                          input logic [63:0] wd, input logic [63:0] exp_d,
                          input bit exp_e, input string tag,
                          input logic [31:0] ev = 32'h0);
        @(negedge clk);
        if (u == 0) begin
            v0 = 1; w0 = wr; i0 = idx; d0 = wd; e0 = ev;
            qd0.push_back(exp_d); qe0.push_back(exp_e); qt0.push_back(tag);
        end else begin
            v1 = 1; w1 = wr; i1 = idx; d1 = wd; e1 = ev;
            qd1.push_back(exp_d); qe1.push_back(exp_e); qt1.push_back(tag);
        end
        @(negedge clk);
        v0 = 0; w0 = 0; v1 = 0; w1 = 0; e0 = '0; e1 = '0;
    endtask

    task automatic pulse(input int u, input logic [31:0] m);
        @(negedge clk);
        if (u == 0) e0 = m; else e1 = m;
        @(negedge clk);
        e0 = '0; e1 = '0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R1 reset state
        check64("R1 resp_valid", {63'd0, rv0}, 64'd0);
        check64("R1 smi outputs", {61'd0, sr0, sa0, ss0}, 64'd0);
        access(0, 0, 4'd2, '0, 64'd0, 0, "R1 smi word after reset");
        access(0, 0, 4'd1, '0, CFG_R, 0, "R3 cfg reset");
        access(0, 0, 4'd3, '0, ERR_R, 0, "R3 err reset");
        access(0, 0, 4'd4, '0, PM_R, 0, "R3 pm reset");

        // R2 identity
        access(0, 0, 4'd0, '0, CAP_EXP, 0, "R2 caps read");
        access(0, 1, 4'd0, '1, 64'd0, 0, "R11 write resp caps");
        access(0, 0, 4'd0, '0, CAP_EXP, 0, "R2 caps after write");

        // R3 full read/write
        access(0, 1, 4'd1, 64'hDEAD_BEEF_0123_4567, 64'd0, 0, "R11 write resp cfg");
        access(0, 0, 4'd1, '0, 64'hDEAD_BEEF_0123_4567, 0, "R3 cfg readback");
        access(0, 1, 4'd3, '1, 64'd0, 0, "R11 write resp err");
        access(0, 0, 4'd3, '0, '1, 0, "R3 err readback");
        access(0, 1, 4'd4, 64'h8000_0000_0000_0001, 64'd0, 0, "R11 write resp pm");
        access(0, 0, 4'd4, '0, 64'h8000_0000_0000_0001, 0, "R3 pm readback");

        // R9 diagnostic
        access(0, 1, 4'd5, '1, 64'd0, 0, "R9 diag write");
        access(0, 0, 4'd5, '0, 64'd0, 0, "R9 diag read zero");

        // R10 out of range
        access(0, 0, 4'd6, '0, 64'd0, 1, "R10 read idx6");
        access(0, 1, 4'd15, 64'h1234, 64'd0, 1, "R10 write idx15");
        access(0, 1, 4'd9, 64'h5555, 64'd0, 1, "R10 write idx9");
        access(0, 0, 4'd1, '0, 64'hDEAD_BEEF_0123_4567, 0, "R10 cfg untouched");

        // R5 normal polarity: disabled event not recorded
        pulse(0, 32'h0000_0010);
        check64("R5 disabled event no req", {63'd0, sr0}, 64'd0);
        access(0, 0, 4'd2, '0, 64'd0, 0, "R5 disabled event no flag");

        // R4 enables, R5 recording, R8 classes
        access(0, 1, 4'd2, 64'h0000_0000_0000_0013, 64'd0, 0, "R4 write enables");
        pulse(0, 32'h0000_00FF);
        check64("R8 async/sync/any", {61'd0, sr0, sa0, ss0}, 64'd7);
        access(0, 0, 4'd2, '0, 64'h0000_0013_0000_0013, 0, "R4 R5 flags and enables");

        // R6 write-one-to-clear, zero leaves
        access(0, 1, 4'd2, 64'h0000_0003_0000_0013, 64'd0, 0, "R6 clear write");
        access(0, 0, 4'd2, '0, 64'h0000_0010_0000_0013, 0, "R6 partial clear");
        check64("R8 sync drops async stays", {61'd0, sr0, sa0, ss0}, 64'd6);
        repeat (5) @(negedge clk);
        access(0, 0, 4'd2, '0, 64'h0000_0010_0000_0013, 0, "R6 sticky flag");

        // R7 event beats clear
        access(0, 1, 4'd2, 64'h0000_0010_0000_0013, 64'd0, 0, "R7 clear with event",
               32'h0000_0010);
        access(0, 0, 4'd2, '0, 64'h0000_0010_0000_0013, 0, "R7 flag survives");
        access(0, 1, 4'd2, 64'h0000_0010_0000_0013, 64'd0, 0, "R6 clear alone");
        access(0, 0, 4'd2, '0, 64'h0000_0000_0000_0013, 0, "R6 flag cleared");
        check64("R8 all requests low", {61'd0, sr0, sa0, ss0}, 64'd0);

        // R5 inverted polarity instance
        pulse(1, 32'h0000_0004);
        check64("R5 R8 inverted sync req", {61'd0, sr1, sa1, ss1}, 64'd5);
        access(1, 0, 4'd2, '0, 64'h0000_0004_0000_0000, 0, "R5 inverted records at en=0");
        access(1, 1, 4'd2, 64'h0000_0004_0000_0008, 64'd0, 0, "R6 inverted clear");
        pulse(1, 32'h0000_0008);
        access(1, 0, 4'd2, '0, 64'h0000_0000_0000_0008, 0, "R5 inverted blocks at en=1");
        check64("R5 inverted no req", {63'd0, sr1}, 64'd0);
        pulse(1, 32'h0000_0001);
        access(1, 0, 4'd2, '0, 64'h0000_0001_0000_0008, 0, "R5 inverted other event");

        repeat (3) @(negedge clk);
        check64("R11 pending responses main", 64'(qd0.size()), 64'd0);
        check64("R11 pending responses inverted", 64'(qd1.size()), 64'd0);
        finish_run();
    end

endmodule